// File: doc/BRIEF.md
# Stack-machine processor core

This block is a multi-cycle processor for a compact stack-oriented instruction set. Program text and the data stack share a single unified word memory. Text starts at word 10, the low ten words are left unused, and the stack begins at the top of memory and grows toward lower addresses. Every instruction takes three consecutive words: an opcode, a lexical level and an operand. The core fetches these one word per cycle, decodes them, and then executes. Variables in enclosing procedures are reached by following static links, one memory read per level.

While reset is held low, a host writes the program image through a plain write port. Releasing reset starts execution at word 10. Character-style output leaves through a valid/ready source port. `tx_valid` rises when an output instruction executes. It stays high, with `tx_data` frozen, until the sink raises `tx_ready`, so a sink may apply back-pressure for any number of cycles. Input arrives through a valid/ready sink port. `rx_ready` is high only while an input instruction waits, and the word is taken in the cycle where `rx_valid` and `rx_ready` are both high. Three plain status flags are exported: halt, illegal instruction and division fault. The PC, BP and SP registers are exported as well.

Top module: `stk_cpu`

## Requirements
- R1: During and right after reset, PC=10, BP=499, SP=500. Halted, illegal and division-fault flags are low, and `tx_valid` and `rx_ready` are low.
- R2: Each instruction is read as opcode, level, operand from PC, PC+1, PC+2, and PC advances by 3 before execution. Opcode 7 (JMP) sets PC to the operand.
- R3: Opcode 1 (LIT) decrements SP and then stores the operand at the new SP. Opcode 6 (INC) subtracts the operand from SP.
- R4: Opcode 2 with operand 1, 2, 3 or 4 computes (second word) op (top word) as add, subtract, multiply or divide. Arithmetic wraps at 32 bits, and division is signed and truncates toward zero. The result replaces the second word and SP increments. A divisor of zero leaves the dividend in place and sets the sticky division-fault flag. The quotient of the most negative value by -1 wraps to the most negative value.
- R5: Opcode 2 with operands 5 to 10 compares the second word against the top word, signed, as equal, not equal, less, less-or-equal, greater and greater-or-equal. The result is 1 or 0.
- R6: Opcodes 3 (LOD) and 4 (STO) address base(L)-M. base(L) starts at BP and is replaced by the word it points to, L times. LOD pushes that word. STO writes the top word there and pops.
- R7: Opcode 5 (CAL) writes base(L) at SP-1, BP at SP-2 and the return PC at SP-3, then sets BP=SP-1 and PC=M. Opcode 2 with operand 0 returns: SP=BP+1, BP is restored from the old BP-1, and PC from the old BP-2.
- R8: Opcode 8 (JPC) jumps to M when the top word is 0 and pops the stack in both cases.
- R9: Opcode 9 with operand 1 presents the top word on `tx_data` with `tx_valid` high. Both are held unchanged while `tx_ready` is low, and SP is popped only after the handshake.
- R10: Opcode 9 with operand 2 raises `rx_ready` and stalls with SP unchanged until `rx_valid`. The accepted `rx_data` is then pushed.
- R11: Opcode 9 with operand 3 halts the core. From then on `halted` stays high and PC, BP and SP no longer change.
- R12: An opcode outside 1 to 9, an opcode 2 operand above 10, or an opcode 9 operand outside 1 to 3 halts the core with `bad_instr` high. PC is left pointing past the offending instruction.
- R13: Host writes while `rst_n` is high have no effect on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; program loading window |
| prog_we | input | 1 | Host write strobe, honoured only in reset |
| prog_addr | input | 9 | Host write word address |
| prog_data | input | 32 | Host write data |
| tx_valid | output | 1 | Output word available |
| tx_ready | input | 1 | Sink accepts output word |
| tx_data | output | 32 | Output word |
| rx_valid | input | 1 | Input word available |
| rx_ready | output | 1 | Core waits for an input word |
| rx_data | input | 32 | Input word |
| halted | output | 1 | Core stopped |
| bad_instr | output | 1 | Stopped on an illegal instruction |
| div_fault | output | 1 | Sticky division-by-zero flag |
| pc_o | output | 9 | Program counter |
| bp_o | output | 9 | Base pointer |
| sp_o | output | 9 | Stack pointer |

## Verification
The arithmetic sweep pairs zero, one, minus one, small odd values and both 32-bit extremes under every operator. It catches unsigned comparison, swapped operand order, floor-style division, and a faulty zero-divisor path that would write garbage or leave the fault flag clear. A two-deep procedure nesting forces a level-2 static-link walk. A walk that stopped one level short, or returned the wrong link, would print the wrong stacked value, and a bad return would lose the caller's frame. JPC is driven with both a zero and a non-zero top, because a design that pops on only one path leaves SP off by one. The output handshake is held off for several cycles, and the input is withheld, so that dropped data, an early pop or a push without a handshake shows up in SP or in the output stream.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_DEC, S_WALK, S_EXE, S_OUT, S_IN, S_HALT
  } st_t;

  localparam logic [3:0] OP_LIT = 4'd1;
  localparam logic [3:0] OP_OPR = 4'd2;
  localparam logic [3:0] OP_LOD = 4'd3;
  localparam logic [3:0] OP_STO = 4'd4;
  localparam logic [3:0] OP_CAL = 4'd5;
  localparam logic [3:0] OP_INC = 4'd6;
  localparam logic [3:0] OP_JMP = 4'd7;
  localparam logic [3:0] OP_JPC = 4'd8;
  localparam logic [3:0] OP_SYS = 4'd9;

  localparam logic [3:0] FN_RET = 4'd0;
  localparam logic [3:0] FN_ADD = 4'd1;
  localparam logic [3:0] FN_SUB = 4'd2;
  localparam logic [3:0] FN_MUL = 4'd3;
  localparam logic [3:0] FN_DIV = 4'd4;
  localparam logic [3:0] FN_EQL = 4'd5;
  localparam logic [3:0] FN_NEQ = 4'd6;
  localparam logic [3:0] FN_LSS = 4'd7;
  localparam logic [3:0] FN_LEQ = 4'd8;
  localparam logic [3:0] FN_GTR = 4'd9;
  localparam logic [3:0] FN_GEQ = 4'd10;

  localparam logic [3:0] SC_PUT  = 4'd1;
  localparam logic [3:0] SC_GET  = 4'd2;
  localparam logic [3:0] SC_STOP = 4'd3;
endpackage

// File: rtl/stk_mem.sv
`timescale 1ns/1ps
module stk_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 500,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [DW-1:0] ram [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we && waddr <= TOP) ram[waddr] <= wdata;
  end

  // addresses beyond the array read as zero
  assign rdata = (raddr <= TOP) ? ram[raddr] : '0;
endmodule

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    fn,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res,
  output logic          dz
);
  logic signed [DW-1:0] sl, sr;
  assign sl = lhs;
  assign sr = rhs;

  always_comb begin
    res = lhs;
    dz  = 1'b0;
    case (fn)
      FN_ADD: res = lhs + rhs;
      FN_SUB: res = lhs - rhs;
      FN_MUL: res = lhs * rhs;
      FN_DIV: begin
        if (rhs == '0)      dz  = 1'b1;
        else if (rhs == '1) res = '0 - lhs;
        else                res = sl / sr;
      end
      FN_EQL: res = DW'(lhs == rhs);
      FN_NEQ: res = DW'(lhs != rhs);
      FN_LSS: res = DW'(sl < sr);
      FN_LEQ: res = DW'(sl <= sr);
      FN_GTR: res = DW'(sl > sr);
      FN_GEQ: res = DW'(sl >= sr);
      default: res = lhs;
    endcase
  end
endmodule

// File: rtl/stk_cpu.sv
`timescale 1ns/1ps
module stk_cpu
  import stk_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEPTH     = 500,
  parameter int TEXT_BASE = 10,
  parameter int AW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  output logic          halted,
  output logic          bad_instr,
  output logic          div_fault,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] bp_o,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] PC0 = AW'(TEXT_BASE);
  localparam logic [AW-1:0] BP0 = AW'(DEPTH - 1);
  localparam logic [AW-1:0] SP0 = AW'(DEPTH);

  st_t           st;
  logic [1:0]    stp;
  logic [AW-1:0] pc_r, bp_r, sp_r, arb;
  logic [3:0]    op;
  logic          op_hi;
  logic [DW-1:0] lv, mv, tmp, lvl, txd;
  logic          bad_r, dz_r;

  logic [AW-1:0] rd_a, c_wa, m_wa;
  logic [DW-1:0] rd_d, c_wd, m_wd;
  logic          c_we, m_we;
  logic [DW-1:0] alu_res;
  logic          alu_dz;
  logic          legal;

  logic [3:0]    m_lo;
  logic          m_hi;
  logic [AW-1:0] m_a, sp_dn, sp_up;
  assign m_lo  = mv[3:0];
  assign m_hi  = |mv[DW-1:4];
  assign m_a   = mv[AW-1:0];
  assign sp_dn = sp_r - AW'(1);
  assign sp_up = sp_r + AW'(1);

  // host owns the write port while reset is held
  assign m_we = rst_n ? c_we : prog_we;
  assign m_wa = rst_n ? c_wa : prog_addr;
  assign m_wd = rst_n ? c_wd : prog_data;

  stk_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_wa), .wdata(m_wd), .raddr(rd_a), .rdata(rd_d)
  );

  stk_alu #(.DW(DW)) u_alu (
    .fn(m_lo), .lhs(rd_d), .rhs(tmp), .res(alu_res), .dz(alu_dz)
  );

  always_comb begin
    legal = 1'b0;
    if (!op_hi) begin
      case (op)
        OP_OPR:  legal = !m_hi && (m_lo <= FN_GEQ);
        OP_SYS:  legal = !m_hi && (m_lo >= SC_PUT) && (m_lo <= SC_STOP);
        OP_LIT, OP_LOD, OP_STO, OP_CAL, OP_INC, OP_JMP, OP_JPC: legal = 1'b1;
        default: legal = 1'b0;
      endcase
    end
  end

  // single read port and single write port sequencing
  always_comb begin
    rd_a = pc_r;
    c_we = 1'b0;
    c_wa = sp_dn;
    c_wd = mv;
    case (st)
      S_F1:   rd_a = pc_r + AW'(1);
      S_F2:   rd_a = pc_r + AW'(2);
      S_WALK: rd_a = arb;
      S_EXE: begin
        case (op)
          OP_LIT: c_we = 1'b1;
          OP_OPR: begin
            if (m_lo == FN_RET) begin
              rd_a = (stp == 2'd0) ? bp_r - AW'(2) : bp_r - AW'(1);
            end else begin
              rd_a = (stp == 2'd0) ? sp_r : sp_up;
              c_we = (stp != 2'd0);
              c_wa = sp_up;
              c_wd = alu_res;
            end
          end
          OP_LOD: begin
            rd_a = arb - m_a;
            c_we = 1'b1;
            c_wd = rd_d;
          end
          OP_STO: begin
            rd_a = sp_r;
            c_we = 1'b1;
            c_wa = arb - m_a;
            c_wd = rd_d;
          end
          OP_CAL: begin
            c_we = 1'b1;
            case (stp)
              2'd0:    begin c_wa = sp_dn;          c_wd = DW'(arb);  end
              2'd1:    begin c_wa = sp_r - AW'(2);  c_wd = DW'(bp_r); end
              default: begin c_wa = sp_r - AW'(3);  c_wd = DW'(pc_r); end
            endcase
          end
          OP_JPC, OP_SYS: rd_a = sp_r;
          default: ;
        endcase
      end
      S_IN: begin
        c_we = rx_valid;
        c_wd = rx_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_F0;  stp <= 2'd0;
      pc_r <= PC0; bp_r <= BP0; sp_r <= SP0; arb <= BP0;
      op <= '0; op_hi <= 1'b0; lv <= '0; mv <= '0; tmp <= '0; lvl <= '0; txd <= '0;
      bad_r <= 1'b0; dz_r <= 1'b0;
    end else begin
      case (st)
        S_F0: begin op <= rd_d[3:0]; op_hi <= |rd_d[DW-1:4]; st <= S_F1; end
        S_F1: begin lv <= rd_d; st <= S_F2; end
        S_F2: begin mv <= rd_d; pc_r <= pc_r + AW'(3); st <= S_DEC; end
        S_DEC: begin
          stp <= 2'd0;
          if (!legal) begin
            bad_r <= 1'b1;
            st    <= S_HALT;
          end else if (op == OP_LOD || op == OP_STO || op == OP_CAL) begin
            arb <= bp_r;
            lvl <= lv;
            st  <= S_WALK;
          end else begin
            st <= S_EXE;
          end
        end
        S_WALK: begin
          if (lvl == '0) st <= S_EXE;
          else begin
            arb <= rd_d[AW-1:0];
            lvl <= lvl - DW'(1);
          end
        end
        S_EXE: begin
          st <= S_F0;
          case (op)
            OP_LIT: sp_r <= sp_dn;
            OP_OPR: begin
              if (stp == 2'd0) begin
                tmp <= rd_d;
                stp <= 2'd1;
                st  <= S_EXE;
              end else if (m_lo == FN_RET) begin
                sp_r <= bp_r + AW'(1);
                bp_r <= rd_d[AW-1:0];
                pc_r <= tmp[AW-1:0];
              end else begin
                sp_r <= sp_up;
                if (alu_dz) dz_r <= 1'b1;
              end
            end
            OP_LOD: sp_r <= sp_dn;
            OP_STO: sp_r <= sp_up;
            OP_CAL: begin
              if (stp == 2'd2) begin
                bp_r <= sp_dn;
                pc_r <= m_a;
              end else begin
                stp <= stp + 2'd1;
                st  <= S_EXE;
              end
            end
            OP_INC: sp_r <= sp_r - m_a;
            OP_JMP: pc_r <= m_a;
            OP_JPC: begin
              if (rd_d == '0) pc_r <= m_a;
              sp_r <= sp_up;
            end
            OP_SYS: begin
              case (m_lo)
                SC_PUT:  begin txd <= rd_d; st <= S_OUT; end
                SC_GET:  st <= S_IN;
                default: st <= S_HALT;
              endcase
            end
            default: st <= S_HALT;
          endcase
        end
        S_OUT: if (tx_ready) begin sp_r <= sp_up; st <= S_F0; end
        S_IN:  if (rx_valid) begin sp_r <= sp_dn; st <= S_F0; end
        default: ;
      endcase
    end
  end

  assign tx_valid  = (st == S_OUT);
  assign tx_data   = txd;
  assign rx_ready  = (st == S_IN);
  assign halted    = (st == S_HALT);
  assign bad_instr = bad_r;
  assign div_fault = dz_r;
  assign pc_o      = pc_r;
  assign bp_o      = bp_r;
  assign sp_o      = sp_r;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F2) |=> (pc_r == $past(pc_r) + AW'(3))); // R2
  AST_DIV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    div_fault |=> div_fault); // R4
  AST_WALK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WALK && lvl == '0) |=> (st == S_EXE)); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(sp_o))); // R9
  AST_RX_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (sp_o == $past(sp_o) - AW'(1))); // R10
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_o) && $stable(sp_o) && $stable(bp_o))); // R11
  AST_BAD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_instr |-> halted); // R12
endmodule

// File: tb/tb_stk_cpu.sv
`timescale 1ns/1ps
module tb_stk_cpu;
  localparam int DW = 32;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_we;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data;
  logic          tx_valid, tx_ready;
  logic [DW-1:0] tx_data;
  logic          rx_valid, rx_ready;
  logic [DW-1:0] rx_data;
  logic          halted, bad_instr, div_fault;
  logic [AW-1:0] pc_o, bp_o, sp_o;

  always #2.5 clk = ~clk;

  stk_cpu #(.DW(DW), .DEPTH(500), .TEXT_BASE(10)) dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .halted(halted), .bad_instr(bad_instr), .div_fault(div_fault),
    .pc_o(pc_o), .bp_o(bp_o), .sp_o(sp_o)
  );

  int nchk = 0;
  int nfail = 0;
  int img [256];
  int nw;
  int outq [$];

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) outq.push_back(int'(tx_data));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int op, input int l, input int m);
    img[nw] = op; img[nw+1] = l; img[nw+2] = m;
    nw += 3;
  endtask

  task automatic boot();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nw; i++) begin
      prog_we = 1'b1; prog_addr = AW'(10 + i); prog_data = img[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    outq.delete();
    rst_n = 1'b1;
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(halted, "R11 halt reached", int'(halted), 1);
  endtask

  function automatic int first_out();
    return (outq.size() > 0) ? outq[0] : -999;
  endfunction

  function automatic int exp_alu(input int fn, input int a, input int b);
    case (fn)
      1: return a + b;
      2: return a - b;
      3: return a * b;
      4: begin
        if (b == 0) return a;
        else if (b == -1) return 0 - a;
        else return a / b;
      end
      5:  return (a == b) ? 1 : 0;
      6:  return (a != b) ? 1 : 0;
      7:  return (a <  b) ? 1 : 0;
      8:  return (a <= b) ? 1 : 0;
      9:  return (a >  b) ? 1 : 0;
      10: return (a >= b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 190000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int vals [8];
    int e, p0, b0, s0;
    vals = '{0, 1, -1, 7, -5, 3, 32'h7fffffff, 32'h80000000};
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    tx_ready = 1'b1; rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(pc_o == 10,  "R1 pc",  int'(pc_o), 10);
    chk(bp_o == 499, "R1 bp",  int'(bp_o), 499);
    chk(sp_o == 500, "R1 sp",  int'(sp_o), 500);
    chk(!halted && !bad_instr && !div_fault, "R1 flags", int'(halted), 0);
    chk(!tx_valid && !rx_ready, "R1 ports", int'(tx_valid), 0);

    // R4 R5 R3: operator sweep
    for (int fn = 1; fn <= 10; fn++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          nw = 0;
          put(1, 0, vals[i]); put(1, 0, vals[j]); put(2, 0, fn);
          put(9, 0, 1); put(9, 0, 3);
          boot();
          wait_halt();
          e = exp_alu(fn, vals[i], vals[j]);
          chk(outq.size() == 1 && outq[0] == e, (fn <= 4) ? "R4 arith" : "R5 relational", first_out(), e);
          chk(sp_o == 500, "R3 sp after sweep", int'(sp_o), 500);
          if (fn == 4) chk(div_fault == (vals[j] == 0), "R4 div fault", int'(div_fault), int'(vals[j] == 0));
        end
      end
    end

    // R2 jump
    nw = 0;
    put(7, 0, 16); put(9, 0, 3); put(1, 0, 5); put(9, 0, 1); put(9, 0, 3);
    boot(); wait_halt();
    chk(outq.size() == 1 && first_out() == 5, "R2 jmp", first_out(), 5);
    chk(pc_o == 25, "R2 pc", int'(pc_o), 25);

    // R3 INC
    nw = 0;
    put(6, 0, 7); put(9, 0, 3);
    boot(); wait_halt();
    chk(sp_o == 493, "R3 inc", int'(sp_o), 493);
    chk(!bad_instr, "R12 legal program", int'(bad_instr), 0);

    // R6 R7 nested calls, level-1 and level-2 walks
    nw = 0;
    put(7, 0, 52);
    put(6, 0, 4); put(1, 0, 6); put(4, 1, 4); put(5, 0, 40);
    put(1, 0, 9); put(4, 0, 3); put(3, 0, 3); put(9, 0, 1); put(2, 0, 0);
    put(6, 0, 3); put(3, 2, 4); put(9, 0, 1); put(2, 0, 0);
    put(6, 0, 5); put(5, 0, 13); put(3, 0, 4); put(9, 0, 1); put(9, 0, 3);
    boot(); wait_halt();
    chk(outq.size() == 3, "R7 output count", outq.size(), 3);
    chk(outq.size() > 0 && outq[0] == 6, "R6 level-2 load", first_out(), 6);
    chk(outq.size() > 1 && outq[1] == 9, "R6 local store/load", (outq.size() > 1) ? outq[1] : -999, 9);
    chk(outq.size() > 2 && outq[2] == 6, "R7 caller frame", (outq.size() > 2) ? outq[2] : -999, 6);
    chk(sp_o == 495, "R7 sp", int'(sp_o), 495);
    chk(bp_o == 499, "R7 bp", int'(bp_o), 499);
    chk(pc_o == 67,  "R2 final pc", int'(pc_o), 67);

    // R8 conditional jump, both directions
    nw = 0;
    put(1, 0, 0); put(8, 0, 22); put(1, 0, 1); put(9, 0, 1);
    put(1, 0, 5); put(8, 0, 37); put(1, 0, 2); put(9, 0, 1); put(9, 0, 3);
    put(1, 0, 77); put(9, 0, 1); put(9, 0, 3);
    boot(); wait_halt();
    chk(outq.size() == 1 && first_out() == 2, "R8 jpc path", first_out(), 2);
    chk(sp_o == 500, "R8 pops", int'(sp_o), 500);

    // R9 output back-pressure
    nw = 0;
    put(1, 0, 123); put(9, 0, 1); put(9, 0, 3);
    tx_ready = 1'b0;
    boot();
    while (!tx_valid) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == 123, "R9 held", int'(tx_data), 123);
      chk(sp_o == 499, "R9 no early pop", int'(sp_o), 499);
    end
    tx_ready = 1'b1;
    wait_halt();
    chk(outq.size() == 1 && first_out() == 123, "R9 delivered once", first_out(), 123);
    chk(sp_o == 500, "R9 pop", int'(sp_o), 500);

    // R10 input stall and push
    nw = 0;
    put(9, 0, 2); put(9, 0, 2); put(2, 0, 2); put(9, 0, 1); put(9, 0, 3);
    boot();
    while (!rx_ready) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rx_ready && sp_o == 500, "R10 stall", int'(sp_o), 500);
    end
    rx_valid = 1'b1; rx_data = 50;
    @(negedge clk);
    rx_valid = 1'b0;
    while (!rx_ready) @(negedge clk);
    chk(sp_o == 499, "R10 push", int'(sp_o), 499);
    rx_valid = 1'b1; rx_data = 8;
    @(negedge clk);
    rx_valid = 1'b0;
    wait_halt();
    chk(outq.size() == 1 && first_out() == 42, "R10 data", first_out(), 42);

    // R11 frozen after halt
    p0 = int'(pc_o); b0 = int'(bp_o); s0 = int'(sp_o);
    repeat (10) @(negedge clk);
    chk(halted && int'(pc_o) == p0 && int'(sp_o) == s0 && int'(bp_o) == b0, "R11 frozen", int'(pc_o), p0);

    // R12 illegal forms
    nw = 0; put(12, 0, 0);
    boot(); wait_halt();
    chk(bad_instr && pc_o == 13, "R12 opcode", int'(pc_o), 13);
    nw = 0; put(2, 0, 11);
    boot(); wait_halt();
    chk(bad_instr && pc_o == 13, "R12 opr operand", int'(pc_o), 13);
    nw = 0; put(9, 0, 7);
    boot(); wait_halt();
    chk(bad_instr && outq.size() == 0, "R12 sys operand", int'(bad_instr), 1);

    // R13 host writes outside reset ignored
    nw = 0; put(1, 0, 42); put(9, 0, 1); put(9, 0, 3);
    boot(); wait_halt();
    chk(first_out() == 42, "R13 baseline", first_out(), 42);
    prog_we = 1'b1; prog_addr = AW'(12); prog_data = 99;
    @(negedge clk);
    prog_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    outq.delete();
    rst_n = 1'b1;
    wait_halt();
    chk(first_out() == 42, "R13 ignored write", first_out(), 42);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule